// File: doc/BRIEF.md
# Fan Tachometer Readout Registers with Minimum-Speed Alert

This block is the register-side logic that sits between a fan period counter and a byte-wide host register port. The counter publishes one 16-bit period count per fan on a single measurement strobe. A larger count means a slower fan. The block keeps the latest count for each fan and shows it to the host as two bytes at consecutive addresses. When the host reads a low byte, the block takes a snapshot of the matching high byte. The host therefore always gets two halves of one measurement, even when a new count lands between the two reads.

Each fan also has a 16-bit minimum-speed limit. This limit is expressed as the largest period count that is still acceptable. Every published count is compared with its fan's limit. A count above the limit, even by a single unit, sets a sticky status bit. Every unmasked status bit pulls the active-low alert line down. The host clears the status by reading it.

Top module: `fan_tach_regs`

## Requirements
- R1: After reset every reading is 0x0000, every limit byte reads 0xFF, the status register (0x41) and the mask register (0x74) read 0, and alert_n is 1.
- R2: Fan i's reading sits at 0x28+2i (low byte) and 0x29+2i (high byte). A read issued on one clock edge shows its byte on bus_rdata after that edge, and the output holds until the next read.
- R3: Reading fan i's low byte takes a snapshot of its high byte. Until fan i's high byte is read, that high-byte address returns the snapshot, whatever measurements arrive in between. The high-byte read releases the snapshot.
- R4: A high-byte read with no snapshot pending returns the high byte of the latest measurement.
- R5: Fan i's limit is writable and readable at 0x54+2i (low byte) and 0x55+2i (high byte).
- R6: A measurement for fan i whose count is strictly greater than fan i's limit sets status bit i (bit i of 0x41). A count equal to or below the limit leaves the bit unchanged.
- R7: Status bits are sticky. A later in-range measurement does not clear them. Reading 0x41 returns the current bits and clears them. A measurement that exceeds its limit in the same cycle as the status read leaves its bit set.
- R8: alert_n is 0 exactly when some status bit i is set while mask bit i (bit i of 0x74) is 0.
- R9: A count of 0xFFFF against the reset limit of 0xFFFF never sets status.
- R10: The comparison uses the full 16-bit new count even while a snapshot of that fan's high byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | A new period count is published this cycle |
| meas_fan | input | 2 | Index of the fan the count belongs to |
| meas_count | input | 16 | Period count (higher means slower) |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe (reads of readings and status have side effects) |
| bus_rdata | output | 8 | Registered read data |
| alert_n | output | 1 | Active-low alert, low while any unmasked status bit is set |

## Verification
A snapshot flag that is stuck or released too early shows up at the high-byte read that follows. That read returns the new measurement's high byte instead of the snapshot, one cycle after the read strobe. An off-by-one in the limit comparison, or a status bit that clears too easily, shows on alert_n in the cycle after the offending measurement and in the next status read. The bench sweeps counts around each fan's limit and checks both ports at those exact cycles. It also sweeps the mask so that alert_n is seen to follow only the unmasked bits.

// File: rtl/fan_tach_regs.sv
module fan_tach_regs #(
  parameter int          NFANS      = 4,
  parameter logic [7:0]  TACH_BASE  = 8'h28,
  parameter logic [7:0]  LIM_BASE   = 8'h54,
  parameter logic [7:0]  STAT_ADDR  = 8'h41,
  parameter logic [7:0]  MASK_ADDR  = 8'h74,
  localparam int         FW         = (NFANS > 1) ? $clog2(NFANS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_valid,
  input  logic [FW-1:0] meas_fan,
  input  logic [15:0]   meas_count,
  input  logic [7:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_rd,
  output logic [7:0]    bus_rdata,
  output logic          alert_n
);

  logic [NFANS-1:0][15:0] rdg, lim;
  logic [NFANS-1:0][7:0]  hold_hi;
  logic [NFANS-1:0]       frozen, status, mask, hit;
  logic [7:0]             rd_mux;
  logic                   stat_rd;

  assign stat_rd = bus_rd && (bus_addr == STAT_ADDR);
  assign alert_n = ~|(status & ~mask);

  always_comb begin
    hit = '0;
    for (int i = 0; i < NFANS; i++)
      if (meas_valid && meas_fan == FW'(i) && meas_count > lim[i]) hit[i] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NFANS; i++) begin
      if (bus_addr == TACH_BASE + 8'(2*i))     rd_mux = rdg[i][7:0];
      if (bus_addr == TACH_BASE + 8'(2*i + 1)) rd_mux = frozen[i] ? hold_hi[i] : rdg[i][15:8];
      if (bus_addr == LIM_BASE + 8'(2*i))      rd_mux = lim[i][7:0];
      if (bus_addr == LIM_BASE + 8'(2*i + 1))  rd_mux = lim[i][15:8];
    end
    if (bus_addr == STAT_ADDR) rd_mux = 8'(status);
    if (bus_addr == MASK_ADDR) rd_mux = 8'(mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdg       <= '0;
      lim       <= '1;
      hold_hi   <= '0;
      frozen    <= '0;
      status    <= '0;
      mask      <= '0;
      bus_rdata <= '0;
    end else begin
      for (int i = 0; i < NFANS; i++) begin
        if (meas_valid && meas_fan == FW'(i)) rdg[i] <= meas_count;
        if (bus_rd && bus_addr == TACH_BASE + 8'(2*i)) begin
          frozen[i]  <= 1'b1;
          hold_hi[i] <= rdg[i][15:8];
        end else if (bus_rd && bus_addr == TACH_BASE + 8'(2*i + 1)) begin
          frozen[i]  <= 1'b0;
        end
        if (bus_wr && bus_addr == LIM_BASE + 8'(2*i))     lim[i][7:0]  <= bus_wdata;
        if (bus_wr && bus_addr == LIM_BASE + 8'(2*i + 1)) lim[i][15:8] <= bus_wdata;
      end
      status <= (stat_rd ? '0 : status) | hit;
      if (bus_wr && bus_addr == MASK_ADDR) mask <= bus_wdata[NFANS-1:0];
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

endmodule

module fan_tach_regs_chk #(
  parameter int         NFANS     = 4,
  parameter logic [7:0] TACH_BASE = 8'h28,
  parameter logic [7:0] STAT_ADDR = 8'h41,
  parameter int         FW        = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   meas_valid,
  input logic [FW-1:0]          meas_fan,
  input logic [15:0]            meas_count,
  input logic [7:0]             bus_addr,
  input logic                   bus_rd,
  input logic                   alert_n,
  input logic [NFANS-1:0]       status,
  input logic [NFANS-1:0]       frozen,
  input logic [NFANS-1:0][15:0] lim
);

  always @(posedge clk)
    if (!rst_n) assert_reset_alert_R1: assert (alert_n);

  assert_status_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == STAT_ADDR && !meas_valid |=> alert_n && status == '0);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == STAT_ADDR) |=> (status & $past(status)) == $past(status));

  assert_over_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid && meas_count > lim[meas_fan] |=> status[$past(meas_fan)]);

  assert_default_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid && lim[meas_fan] == 16'hFFFF && !(bus_rd && bus_addr == STAT_ADDR)
      |=> status[$past(meas_fan)] == $past(status[meas_fan]));

  for (genvar g = 0; g < NFANS; g++) begin : g_fz
    assert_freeze_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == TACH_BASE + 8'(2*g) |=> frozen[g]);
    assert_freeze_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == TACH_BASE + 8'(2*g + 1) |=> !frozen[g]);
  end

endmodule

bind fan_tach_regs fan_tach_regs_chk #(
  .NFANS(NFANS), .TACH_BASE(TACH_BASE), .STAT_ADDR(STAT_ADDR), .FW(FW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_fan(meas_fan),
  .meas_count(meas_count), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .alert_n(alert_n), .status(status), .frozen(frozen), .lim(lim)
);

// File: tb/sim_fan_tach_regs.sv
`timescale 1ns/1ps
module sim_fan_tach_regs;
  logic clk = 0, rst_n = 0;
  logic meas_valid = 0;
  logic [1:0] meas_fan = 0;
  logic [15:0] meas_count = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_rdata;
  logic alert_n;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  fan_tach_regs u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic meas(input int f, input logic [15:0] c);
    @(negedge clk); meas_fan = 2'(f); meas_count = c; meas_valid = 1;
    @(negedge clk); meas_valid = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [15:0] lim [4];
    logic [3:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 alert_n", alert_n, 1);
    rd(8'h41, d); chk("R1 status", d, 0);
    rd(8'h74, d); chk("R1 mask", d, 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h54 + 8'(2*i), d); chk("R1 limit lo", d, 8'hFF);
      rd(8'h55 + 8'(2*i), d); chk("R1 limit hi", d, 8'hFF);
      rd(8'h29 + 8'(2*i), d); chk("R1 reading hi", d, 0);
      rd(8'h28 + 8'(2*i), d); chk("R1 reading lo", d, 0);
      rd(8'h29 + 8'(2*i), d);
    end

    // R9 full-scale count against default limits
    for (int i = 0; i < 4; i++) begin
      meas(i, 16'hFFFF);
      chk("R9 alert_n", alert_n, 1);
    end
    rd(8'h41, d); chk("R9 status", d, 0);

    // R5 limit programming
    for (int i = 0; i < 4; i++) begin
      lim[i] = 16'h12F0 + 16'(i) * 16'h1111;
      wr(8'h54 + 8'(2*i), lim[i][7:0]);
      wr(8'h55 + 8'(2*i), lim[i][15:8]);
    end
    for (int i = 0; i < 4; i++) begin
      rd(8'h54 + 8'(2*i), d); chk("R5 limit lo", d, lim[i][7:0]);
      rd(8'h55 + 8'(2*i), d); chk("R5 limit hi", d, lim[i][15:8]);
    end

    // R6/R2/R4/R7/R8 sweep around each limit
    for (int i = 0; i < 4; i++) begin
      for (int dl = -20; dl <= 20; dl++) begin
        logic [15:0] c;
        c = 16'(int'(lim[i]) + dl);
        meas(i, c);
        chk("R8 alert after meas", alert_n, (dl > 0) ? 0 : 1);
        rd(8'h29 + 8'(2*i), d); chk("R4 hi unfrozen", d, c[15:8]);
        rd(8'h28 + 8'(2*i), d); chk("R2 lo", d, c[7:0]);
        rd(8'h29 + 8'(2*i), d); chk("R2 hi", d, c[15:8]);
        rd(8'h41, d); chk("R6 status", d, (dl > 0) ? (1 << i) : 0);
        chk("R7 alert cleared", alert_n, 1);
      end
    end

    // R3 freeze, R10 compare during freeze
    meas(0, 16'h1234);
    rd(8'h28, d); chk("R3 lo", d, 8'h34);
    meas(0, 16'hAB00);
    chk("R10 alert during freeze", alert_n, 0);
    rd(8'h29, d); chk("R3 frozen hi", d, 8'h12);
    rd(8'h29, d); chk("R3 released hi", d, 8'hAB);
    rd(8'h28, d); chk("R3 new lo", d, 8'h00);
    meas(0, 16'h0001);
    rd(8'h29, d); chk("R3 frozen again", d, 8'hAB);
    rd(8'h41, d); chk("R10 status", d, 1);

    // R7 sticky across in-range measurement
    meas(1, lim[1] + 16'd1);
    meas(1, 16'h0000);
    chk("R7 sticky alert", alert_n, 0);
    rd(8'h41, d); chk("R7 sticky status", d, 2);
    // R7 set wins over clear in the same cycle
    meas(2, lim[2] + 16'd5);
    @(negedge clk);
    bus_addr = 8'h41; bus_rd = 1; meas_fan = 3; meas_count = lim[3] + 16'd1; meas_valid = 1;
    @(negedge clk);
    bus_rd = 0; meas_valid = 0; d = bus_rdata;
    chk("R7 read returns old", d, 4);
    chk("R7 alert kept", alert_n, 0);
    rd(8'h41, d); chk("R7 set wins", d, 8);

    // R8 mask sweep
    for (int m = 0; m < 16; m++) begin
      wr(8'h74, 8'(m));
      rd(8'h74, d); chk("R8 mask readback", d, m);
      for (int f = 0; f < 4; f++) begin
        meas(f, lim[f] + 16'd2);
        chk("R8 alert masked", alert_n, ((m >> f) & 1) ? 1 : 0);
        rd(8'h41, d); chk("R8 status under mask", d, 1 << f);
      end
    end
    wr(8'h74, 8'h0F);
    meas(3, 16'hFFFF);
    chk("R8 all masked", alert_n, 1);
    wr(8'h74, 8'h00);
    chk("R8 unmask raises", alert_n, 0);
    rd(8'h41, d); st = d[3:0]; chk("R8 status", st, 8);

    finish_run();
  end
endmodule